// File: doc/BRIEF.md
# Voltage-Frequency Transition Sequencer

This block steers a processor core from the operating point it is running at to a new one chosen by a performance level between 0 and 100. An operating point is a 6-bit frequency code and a 5-bit voltage code. A smaller voltage code means a higher supply voltage. The level selects one row of an externally supplied table of operating points, which is sorted from slowest to fastest. The block then drives an external frequency/voltage controller through a sequence of 64-bit control-word writes.

The sequence has three phases. First, the supply is raised toward the target in coarse steps, followed by a few single-step overshoot writes. Second, the frequency is walked toward the target in steps of two on a remapped oscillator scale, and then set exactly. Third, the voltage code is trimmed to its final value. After every write the block polls the controller's 64-bit status word until the pending flag drops. It then reloads the current codes from that word and waits a settle time counted in base time units. One base unit is `TICK_CYCLES` clock cycles.

A request is accepted only while `busy` is low. `done` pulses once when a request ends, whether it was dropped, completed or aborted. `err` reports an aborted sequence and holds until the next accepted request.

Top module: `vf_sequencer`

## Requirements
- R1: The table row used is (level × n_states + 1) / 101 in integer division, clamped to n_states − 1. Row i occupies bits [6i+5:6i] of `tab_fid` and bits [5i+4:5i] of `tab_vid`.
- R2: A request is dropped, with no write and a `done` pulse, in two cases: the status pending flag is set when the request is accepted, or the status codes already equal the selected row.
- R3: Each control word places the frequency code in bits 5:0, the voltage code in bits 12:8, a 1 in bit 16 and a count in bits 63:32. All other bits are 0. The count is 1 for voltage writes and `cfg_pll` × 200 for frequency writes.
- R4: While the current voltage code exceeds the target, the block writes the current code minus 2^`cfg_mvs`, floored at 0, with the current frequency code.
- R5: Next, the block issues up to `cfg_rvo` further writes, each lowering the voltage code by one. It stops early once the code is 0. This phase runs even when the voltage is going down.
- R6: If the frequency code differs from the target, the block steps it while the distance between the two codes on the oscillator scale exceeds 2. The oscillator scale maps codes below 8 to 8 + 2·code and leaves other codes unchanged. An upward step is to current + 2 when current > 6, otherwise to scale(current) + 2. A downward step is to current − 2.
- R7: After the stepping loop, the exact target frequency code is written once. If the voltage code then differs from the target, the target voltage code is written with the current frequency code.
- R8: No write is issued while the status pending flag is set, and no two writes are issued back to back.
- R9: After a voltage write clears, at least 20 × `cfg_vst` × `TICK_CYCLES` cycles pass before the next write. After a frequency write, at least 10 × 2^`cfg_irt` × `TICK_CYCLES` cycles pass.
- R10: If pending stays set for `POLL_LIMIT` polls, the block aborts with no further writes, raises `err` and pulses `done`. The next accepted request clears `err`.
- R11: `busy` is high from an accepted request to its end. A request made while busy is ignored. `done` is only high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_level | input | 7 | Performance level 0..100 |
| n_states | input | $clog2(NSTATE)+1 | Number of valid table rows, at least 1 |
| tab_fid | input | 6·NSTATE | Frequency codes of the table rows |
| tab_vid | input | 5·NSTATE | Voltage codes of the table rows |
| cfg_mvs | input | 2 | Log2 of the coarse voltage step |
| cfg_rvo | input | 2 | Number of overshoot voltage steps |
| cfg_irt | input | 2 | Frequency settle exponent |
| cfg_vst | input | 5 | Voltage settle multiplier |
| cfg_pll | input | 7 | Lock-time factor for frequency write counts |
| sts_word | input | 64 | Controller status: pending bit 31, frequency 5:0, voltage 36:32 |
| ctl_wr | output | 1 | One-cycle control-word write strobe |
| ctl_word | output | 64 | Control word, valid with `ctl_wr` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Last sequence aborted on a stuck pending flag |

## Verification
The assertions rely on three properties of the controller. It raises its pending flag in the cycle after a write strobe. It never shows pending on its own while a sequence is between writes, except when it is stuck. It keeps the table and configuration inputs steady while `busy` is high. The bench's controller model enforces these. It sets pending on the edge that samples `ctl_wr` and clears it a fixed latency later while loading the written codes. The pending flag is only forced from outside while the block is idle, or held stuck to provoke the abort path. Table contents and configuration change only between requests.

// File: rtl/vf_sequencer.sv
module vf_sequencer #(
  parameter int NSTATE      = 16,
  parameter int TICK_CYCLES = 4,
  parameter int POLL_LIMIT  = 100000,
  localparam int IW = (NSTATE > 1) ? $clog2(NSTATE) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [6:0]            req_level,
  input  logic [IW:0]           n_states,
  input  logic [NSTATE*6-1:0]   tab_fid,
  input  logic [NSTATE*5-1:0]   tab_vid,
  input  logic [1:0]            cfg_mvs,
  input  logic [1:0]            cfg_rvo,
  input  logic [1:0]            cfg_irt,
  input  logic [4:0]            cfg_vst,
  input  logic [6:0]            cfg_pll,
  input  logic [63:0]           sts_word,
  output logic                  ctl_wr,
  output logic [63:0]           ctl_word,
  output logic                  busy,
  output logic                  done,
  output logic                  err
);

  localparam int PW = IW + 8;

  typedef enum logic [3:0] {
    S_IDLE, S_RAISE, S_RVO, S_FENTRY, S_FSTEP, S_VFIN,
    S_ISSUE, S_POLL, S_SETTLE, S_END
  } st_t;

  function automatic logic [6:0] vco(input logic [5:0] f);
    return (f < 6'd8) ? 7'(7'd8 + {f, 1'b0}) : {1'b0, f};
  endfunction

  function automatic logic [63:0] mk(input logic [5:0] f, input logic [4:0] v,
                                     input logic [31:0] cnt);
    return {cnt, 15'd0, 1'b1, 3'd0, v, 2'd0, f};
  endfunction

  st_t         st, ret_st;
  logic [5:0]  tfid, cfid;
  logic [4:0]  tvid, cvid;
  logic [1:0]  rvo_left;
  logic        use_irt;
  logic [31:0] poll_cnt, wait_cnt;

  wire       sts_pend = sts_word[31];
  wire [5:0] sts_fid  = sts_word[5:0];
  wire [4:0] sts_vid  = sts_word[36:32];

  logic [PW-1:0] prod, idx_raw, idx_cl;
  assign prod    = PW'(req_level) * PW'(n_states);
  assign idx_raw = (prod + PW'(1)) / PW'(101);
  assign idx_cl  = (idx_raw >= PW'(n_states)) ? PW'(n_states) - PW'(1) : idx_raw;

  wire [5:0] sel_fid = tab_fid[int'(idx_cl[IW-1:0])*6 +: 6];
  wire [4:0] sel_vid = tab_vid[int'(idx_cl[IW-1:0])*5 +: 5];

  logic [6:0] vco_c, vco_t, vdist;
  assign vco_c = vco(cfid);
  assign vco_t = vco(tfid);
  assign vdist = (vco_t > vco_c) ? vco_t - vco_c : vco_c - vco_t;

  logic [5:0] step_fid, mstep;
  logic [4:0] raise_vid;
  assign step_fid  = (tfid > cfid) ? ((cfid > 6'd6) ? cfid + 6'd2 : vco_c[5:0] + 6'd2)
                                   : cfid - 6'd2;
  assign mstep     = 6'd1 << cfg_mvs;
  assign raise_vid = ({1'b0, cvid} >= mstep) ? 5'({1'b0, cvid} - mstep) : 5'd0;

  wire [31:0] fcnt  = 32'(cfg_pll) * 32'd200;
  wire [31:0] dly_v = 32'(cfg_vst) * 32'(20 * TICK_CYCLES);
  wire [31:0] dly_i = (32'd10 << cfg_irt) * 32'(TICK_CYCLES);

  logic        iss, iirt;
  logic [63:0] iw;
  st_t         iret, skip;

  always_comb begin
    iss  = 1'b0;
    iirt = 1'b0;
    iw   = '0;
    iret = S_IDLE;
    skip = S_IDLE;
    case (st)
      S_RAISE:
        if (cvid > tvid) begin
          iss = 1'b1; iw = mk(cfid, raise_vid, 32'd1); iret = S_RAISE;
        end else skip = S_RVO;
      S_RVO:
        if (rvo_left != 2'd0 && cvid != 5'd0) begin
          iss = 1'b1; iw = mk(cfid, cvid - 5'd1, 32'd1); iret = S_RVO;
        end else skip = S_FENTRY;
      S_FENTRY:
        skip = (cfid == tfid) ? S_VFIN : S_FSTEP;
      S_FSTEP: begin
        iss  = 1'b1;
        iirt = 1'b1;
        if (vdist > 7'd2) begin
          iw = mk(step_fid, cvid, fcnt); iret = S_FSTEP;
        end else begin
          iw = mk(tfid, cvid, fcnt); iret = S_VFIN;
        end
      end
      S_VFIN:
        if (cvid != tvid) begin
          iss = 1'b1; iw = mk(cfid, tvid, 32'd1); iret = S_END;
        end else skip = S_END;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ret_st   <= S_IDLE;
      tfid     <= '0;
      tvid     <= '0;
      cfid     <= '0;
      cvid     <= '0;
      rvo_left <= '0;
      use_irt  <= 1'b0;
      poll_cnt <= '0;
      wait_cnt <= '0;
      ctl_wr   <= 1'b0;
      ctl_word <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done   <= 1'b0;
      ctl_wr <= 1'b0;
      case (st)
        S_IDLE:
          if (req_valid) begin
            err <= 1'b0;
            if (sts_pend || (sts_fid == sel_fid && sts_vid == sel_vid)) begin
              done <= 1'b1;
            end else begin
              tfid     <= sel_fid;
              tvid     <= sel_vid;
              cfid     <= sts_fid;
              cvid     <= sts_vid;
              rvo_left <= cfg_rvo;
              st       <= S_RAISE;
            end
          end
        S_RAISE, S_RVO, S_FENTRY, S_FSTEP, S_VFIN:
          if (iss) begin
            ctl_wr   <= 1'b1;
            ctl_word <= iw;
            ret_st   <= iret;
            use_irt  <= iirt;
            st       <= S_ISSUE;
            if (st == S_RVO) rvo_left <= rvo_left - 2'd1;
          end else begin
            st <= skip;
          end
        S_ISSUE: begin
          poll_cnt <= '0;
          st       <= S_POLL;
        end
        S_POLL:
          if (!sts_pend) begin
            cfid     <= sts_fid;
            cvid     <= sts_vid;
            wait_cnt <= use_irt ? dly_i : dly_v;
            st       <= S_SETTLE;
          end else if (poll_cnt == 32'(POLL_LIMIT - 1)) begin
            err <= 1'b1;
            st  <= S_END;
          end else begin
            poll_cnt <= poll_cnt + 32'd1;
          end
        S_SETTLE:
          if (wait_cnt == 32'd0) st <= ret_st;
          else wait_cnt <= wait_cnt - 32'd1;
        S_END: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy = (st != S_IDLE);

  AST_WR_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |-> !sts_word[31]) else $error("write while pending"); // R8
  AST_WR_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !ctl_wr) else $error("back-to-back writes"); // R8
  AST_WR_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |-> (ctl_word[16] && ctl_word[31:17] == 15'd0 && ctl_word[15:13] == 3'd0
                && ctl_word[7:6] == 2'd0 && ctl_word[63:32] != 32'd0)) else $error("word format"); // R3
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ctl_wr) else $error("write while idle"); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy) else $error("done while busy"); // R11
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !ctl_wr) else $error("write after abort"); // R10

endmodule

// File: tb/vf_sequencer_bench.sv
module vf_sequencer_bench;
  localparam int NS = 16;
  localparam int TICK = 2;
  localparam int PLIM = 40;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [6:0] req_level = '0;
  logic [4:0] n_st = 5'd4;
  logic [5:0] tf [NS];
  logic [4:0] tv [NS];
  logic [NS*6-1:0] tab_fid_b;
  logic [NS*5-1:0] tab_vid_b;
  logic [1:0] mvs = 2'd1, rvo = 2'd2, irt = 2'd0;
  logic [4:0] vst = 5'd1;
  logic [6:0] pll = 7'd5;
  logic [63:0] sts_word, ctl_word;
  logic ctl_wr, busy, done, err;

  always_comb
    for (int i = 0; i < NS; i++) begin
      tab_fid_b[i*6 +: 6] = tf[i];
      tab_vid_b[i*5 +: 5] = tv[i];
    end

  vf_sequencer #(.NSTATE(NS), .TICK_CYCLES(TICK), .POLL_LIMIT(PLIM)) u_vf_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .n_states(n_st), .tab_fid(tab_fid_b), .tab_vid(tab_vid_b),
    .cfg_mvs(mvs), .cfg_rvo(rvo), .cfg_irt(irt), .cfg_vst(vst), .cfg_pll(pll),
    .sts_word(sts_word), .ctl_wr(ctl_wr), .ctl_word(ctl_word),
    .busy(busy), .done(done), .err(err));

  // controller model
  logic pend, stuck = 1'b0, force_pend = 1'b0;
  logic [5:0] cur_fid;
  logic [4:0] cur_vid;
  logic [63:0] pw;
  int lat;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; cur_fid <= 6'd2; cur_vid <= 5'd20; lat <= 0; pw <= '0;
    end else if (ctl_wr) begin
      pend <= 1'b1; lat <= 3; pw <= ctl_word;
    end else if (pend && !stuck) begin
      if (lat == 0) begin
        pend <= 1'b0; cur_fid <= pw[5:0]; cur_vid <= pw[12:8];
      end else lat <= lat - 1;
    end
  end
  assign sts_word = {27'd0, cur_vid, pend | force_pend, 25'd0, cur_fid};

  int checks = 0, fails = 0;
  logic [63:0] exp_q [$];
  int exp_f, exp_v;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: writes compared against the model on every clock
  bit first_wr = 1'b1, last_irt = 1'b0, prev_pend = 1'b0;
  int clear_cyc = 0;
  always @(negedge clk) begin
    if (prev_pend && !pend) clear_cyc = cyc;
    prev_pend = pend;
    if (rst_n && ctl_wr) begin
      if (exp_q.size() == 0) chk(1'b0, "R4-R7", "unexpected write", ctl_word, 0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk(ctl_word == e, "R3/R4/R5/R6/R7", "write word", ctl_word, e);
      end
      if (!first_wr) begin
        int need;
        need = last_irt ? (10 << irt) * TICK : 20 * vst * TICK;
        chk(cyc - clear_cyc >= need, "R9", "settle gap", cyc - clear_cyc, need);
      end
      first_wr = 1'b0;
      last_irt = (ctl_word[63:32] != 64'd1);
    end
  end

  always @(posedge clk)
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", "timeout", cyc, 150000);
      summary();
    end

  function automatic int vcof(input int f);
    return (f < 8) ? 8 + 2 * f : f;
  endfunction

  function automatic logic [63:0] wd(input int f, input int v, input int c);
    return {32'(c), 15'd0, 1'b1, 3'd0, 5'(v), 2'd0, 6'(f)};
  endfunction

  task automatic model(input int lvl);
    int idx, f, v, cf, cv, val;
    exp_q.delete();
    idx = (lvl * int'(n_st) + 1) / 101;
    if (idx >= int'(n_st)) idx = int'(n_st) - 1;
    f = tf[idx]; v = tv[idx];
    cf = cur_fid; cv = cur_vid;
    exp_f = cf; exp_v = cv;
    if (pend || force_pend || (cf == f && cv == v)) return;
    while (cv > v) begin
      val = cv - (1 << mvs); if (val < 0) val = 0;
      exp_q.push_back(wd(cf, val, 1)); cv = val;
    end
    for (int r = rvo; r > 0 && cv > 0; r--) begin
      cv = cv - 1; exp_q.push_back(wd(cf, cv, 1));
    end
    if (cf != f) begin
      while ((vcof(f) > vcof(cf) ? vcof(f) - vcof(cf) : vcof(cf) - vcof(f)) > 2) begin
        if (f > cf) val = (cf > 6) ? cf + 2 : vcof(cf) + 2;
        else val = cf - 2;
        exp_q.push_back(wd(val, cv, pll * 200)); cf = val;
      end
      exp_q.push_back(wd(f, cv, pll * 200)); cf = f;
    end
    if (cv != v) exp_q.push_back(wd(cf, v, 1));
    exp_f = f; exp_v = v;
  endtask

  task automatic run(input int lvl, input string tag, input bit exp_err,
                     input int intrude_lvl);
    bit seen = 1'b0;
    model(lvl);
    if (exp_err) while (exp_q.size() > 1) void'(exp_q.pop_back());
    first_wr = 1'b1;
    @(negedge clk); req_level = 7'(lvl); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      if (done) begin seen = 1'b1; break; end
      if (intrude_lvl >= 0 && k == 30) begin req_level = 7'(intrude_lvl); req_valid = 1'b1; end
      if (k == 31) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(seen, tag, "done pulse", seen, 1);
    chk(!busy, "R11", "idle at done", busy, 0);
    chk(err == exp_err, "R10", "err flag", err, exp_err);
    chk(exp_q.size() == 0, tag, "writes missing", exp_q.size(), 0);
    if (!exp_err) begin
      repeat (8) @(negedge clk);
      chk(cur_fid == 6'(exp_f) && cur_vid == 5'(exp_v), "R1", "final point",
          {cur_fid, cur_vid}, {6'(exp_f), 5'(exp_v)});
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin tf[i] = 6'd0; tv[i] = 5'd0; end
    tf[0] = 6'd2;  tv[0] = 5'd20;
    tf[1] = 6'd8;  tv[1] = 5'd16;
    tf[2] = 6'd14; tv[2] = 5'd12;
    tf[3] = 6'd20; tv[3] = 5'd8;
    repeat (3) @(negedge clk);
    chk(!busy && !ctl_wr && !done && !err, "R11", "reset state",
        {busy, ctl_wr, done, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R4 R5 R6 R7: upward, coarse raise, overshoot, stepped climb
    run(100, "R4", 1'b0, -1);
    // R5 R6: overshoot on a downward move, stepped descent, irt settle
    irt = 2'd1;
    run(0, "R6", 1'b0, -1);
    // R2: already at target
    run(0, "R2", 1'b0, -1);
    // R2: pending already set
    force_pend = 1'b1;
    run(100, "R2", 1'b0, -1);
    force_pend = 1'b0;
    // R1 R11: level 51 selects row 2; a request while busy is ignored
    irt = 2'd0;
    run(51, "R11", 1'b0, 100);
    // R4 R5 R7: floor at 0, early overshoot stop, voltage-only change
    tf[1] = 6'd14; tv[1] = 5'd2; mvs = 2'd3;
    run(50, "R5", 1'b0, -1);
    // R10: stuck pending aborts after the first write
    mvs = 2'd1; stuck = 1'b1;
    run(100, "R10", 1'b1, -1);
    stuck = 1'b0;
    repeat (10) @(negedge clk);
    // R1 R10: clamp with one row; err clears on next request
    n_st = 5'd1;
    run(100, "R1", 1'b0, -1);
    summary();
  end
endmodule